// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block turns packed 32-bit command words from a host into complete I2C master messages. The host writes one word at a time into a single-entry command buffer. An address frame opens a message and fixes its byte count, its direction and whether it ends with a stop. For a write message, the host then supplies one data frame per byte. For a read message, the block clocks in the counted bytes by itself and passes each one through a one-entry receive register. Because a message may end without a stop, the next address frame produces a repeated start, and combined messages are built from successive command words.

All SCL/SDA waveform timing, including clock stretching and the timeout counter, belongs to an external bit engine. The sequencer asks the engine for one bus operation at a time through a request/done handshake. The operations are START (`be_op`=0), STOP (`be_op`=1) and BIT (`be_op`=2). A BIT operation drives `be_sda_out`, where 1 means released, and returns the sampled line on `be_sda_in`. A repeated start is an ordinary START issued while the bus is still held.

The controller is a single FSM with these states:
- IDLE polls the buffer and takes a valid word. It goes to START for an address frame and to BITS for a data frame.
- START goes to BITS on done.
- BITS runs eight bit operations, MSB first. A write then goes to ACK; a read goes to RXPUT.
- RXPUT waits for the receive register to be free, loads it, and goes to ACK.
- ACK runs the ninth bit. It then goes to STOP on NACK, to BITS for the next read byte, or to IDLE to wait for the next write byte. When the count is used up, it goes to STOP if the stop was requested and otherwise to IDLE.
- STOP goes back to IDLE on done.
- A timeout in START, BITS or ACK leads to STOP.

Top module: `i2cm_xact_ctrl`

## Requirements
- R1: While reset is asserted, `irq_flags`, `cmd_pending`, `rx_full` and `be_req` are all 0.
- R2: A written word is buffered only when its bit 17 (valid) is 1; a word with bit 17 clear causes no buffering and no bus operation. A word written while `cmd_pending` is 1 is dropped, the buffered word is kept, and overrun flag bit 4 is set.
- R3: When a word is taken from the buffer and its bit 18 is 1, transmit flag bit 0 is set; when bit 18 is 0 it is not.
- R4: A word with bit 16 set (address frame) is preceded by a START operation; a word with bit 16 clear sends its byte with no START.
- R5: The byte in bits [29:22] goes out as eight BIT operations, MSB first, followed by a ninth BIT with SDA released whose sample is the slave acknowledge.
- R6: A high acknowledge sample on a transmitted byte sets NACK flag bit 2, issues STOP, and ends the message without sending further bytes.
- R7: When an address frame has bit 22 (R/W) at 1, the block reads the count of bytes without further commands. Each byte is presented on `rx_word[15:8]`, with the driven acknowledge in `rx_word[7]`, and sets receive flag bit 1. Every byte except the last is acknowledged low; the last is released.
- R8: While `rx_full` is 1, a completed read byte is held and no bus operation is requested until `rx_rd` frees the register.
- R9: After the last counted byte the block issues STOP only if the address frame had bit 15 set. Otherwise it issues no STOP, and the next address frame starts with a START.
- R10: The byte count in bits [14:7] of the address frame excludes the address. A count of 0 sends only the address byte.
- R11: `be_timeout` arriving with `be_done` sets timeout flag bit 3, issues STOP, and abandons the message.
- R12: Flags stay set until a 1 is written to the matching `flag_clr` bit; other flag bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_word | input | 32 | Packed command word |
| cmd_pending | output | 1 | Command buffer holds a word not yet taken |
| rx_rd | input | 1 | Host has read the receive register |
| rx_word | output | 16 | Received byte [15:8], driven acknowledge [7], zeros below |
| rx_full | output | 1 | Receive register holds an unread byte |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| irq_flags | output | 5 | Sticky flags: 0 tx, 1 rx, 2 nack, 3 timeout, 4 overrun |
| be_req | output | 1 | Bus operation request to the bit engine |
| be_op | output | 2 | Requested operation: 0 START, 1 STOP, 2 BIT |
| be_sda_out | output | 1 | SDA value for a BIT operation, 1 is released |
| be_done | input | 1 | Bit engine completed the requested operation |
| be_sda_in | input | 1 | SDA sampled during the completed BIT operation |
| be_timeout | input | 1 | Completed operation ended by a clock-stretch timeout |

## Verification
The bench targets the points where the message state can go wrong:
- A NACK on the address byte. A design that ignores it would keep sending data after the slave refused.
- A zero byte count. A wrong design would either stall waiting for data or run a phantom byte.
- A combined write-then-read with no stop in between. A wrong design would insert a STOP or lose the repeated START.
- A second word written while one is still buffered. It must be dropped, not allowed to overwrite the buffered byte.
- A receive register left unread. The engine must then see no request, rather than have a byte overwritten.
- A timeout mid-byte. The message must be abandoned with a STOP instead of continuing with the remaining bits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 8;
    localparam int NFLAG     = 5;
    localparam int BIT_W     = $clog2(DATA_W);
    localparam int RXW_W     = 2 * DATA_W;

    localparam int F_DATA_LSB = 22;
    localparam int F_TXIE     = 18;
    localparam int F_VALID    = 17;
    localparam int F_ADDR     = 16;
    localparam int F_STOP     = 15;
    localparam int F_CNT_LSB  = 7;

    localparam int FL_TX   = 0;
    localparam int FL_RX   = 1;
    localparam int FL_NACK = 2;
    localparam int FL_TMO  = 3;
    localparam int FL_OVR  = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_BIT   = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_RXPUT,
        ST_ACK,
        ST_STOP
    } xact_st_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              txie;
        logic              addr_frm;
        logic              stop_req;
        logic [CNT_W-1:0]  cnt;
    } cmd_t;
endpackage

// File: rtl/i2cm_cmd_buf.sv
module i2cm_cmd_buf
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMD_W-1:0] wdata,
    input  logic             take,
    output logic             valid,
    output cmd_t             cmd,
    output logic             ovr
);
    cmd_t dec;
    logic unused_fields;

    always_comb begin
        dec.data     = wdata[F_DATA_LSB +: DATA_W];
        dec.txie     = wdata[F_TXIE];
        dec.addr_frm = wdata[F_ADDR];
        dec.stop_req = wdata[F_STOP];
        dec.cnt      = wdata[F_CNT_LSB +: CNT_W];
    end

    assign unused_fields = ^{wdata[CMD_W-1:F_DATA_LSB+DATA_W],
                             wdata[F_DATA_LSB-1:F_TXIE+1],
                             wdata[F_CNT_LSB-1:0]};

    assign ovr = wr && valid && !take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            cmd   <= '0;
        end else if (wr && (!valid || take)) begin
            valid <= wdata[F_VALID];
            cmd   <= dec;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    // R2: a buffered word that is not taken survives any write attempt
    a_r2_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take) |=> (valid && $stable(cmd)));
endmodule

// File: rtl/i2cm_rx_buf.sv
module i2cm_rx_buf
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_ack,
    input  logic              rd,
    output logic              full,
    output logic [RXW_W-1:0]  word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (load) begin
            full <= 1'b1;
            word <= {ld_data, ld_ack, {(DATA_W-1){1'b0}}};
        end else if (rd) begin
            full <= 1'b0;
        end
    end

    // R8: the controller never loads over an unread byte
    a_r8_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && full));
endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= set[i] | (flags[i] & ~clr[i]);
        end

        // R12: a set flag without a clear stays set
        a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/i2cm_xact_ctrl.sv
module i2cm_xact_ctrl
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_pending,
    input  logic              rx_rd,
    output logic [RXW_W-1:0]  rx_word,
    output logic              rx_full,
    input  logic [NFLAG-1:0]  flag_clr,
    output logic [NFLAG-1:0]  irq_flags,
    output logic              be_req,
    output logic [1:0]        be_op,
    output logic              be_sda_out,
    input  logic              be_done,
    input  logic              be_sda_in,
    input  logic              be_timeout
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    xact_st_e          state, nxt;
    cmd_t              cmd;
    logic              take, ovr, rx_ld, set_nack, set_tmo;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic              is_addr, rw_lat, stop_lat;
    logic [CNT_W-1:0]  remain;
    logic              rd_phase, last_byte;
    xact_st_e          end_st;
    logic [NFLAG-1:0]  flag_set;

    i2cm_cmd_buf u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_word),
        .take(take), .valid(cmd_pending), .cmd(cmd), .ovr(ovr)
    );

    i2cm_rx_buf u_rx (
        .clk(clk), .rst_n(rst_n), .load(rx_ld), .ld_data(shreg),
        .ld_ack(last_byte), .rd(rx_rd), .full(rx_full), .word(rx_word)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FL_TX]   = take && cmd.txie;
        flag_set[FL_RX]   = rx_ld;
        flag_set[FL_NACK] = set_nack;
        flag_set[FL_TMO]  = set_tmo;
        flag_set[FL_OVR]  = ovr;
    end

    i2cm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(irq_flags)
    );

    assign rd_phase  = rw_lat && !is_addr;
    assign last_byte = (remain <= ONE_CNT);
    assign end_st    = stop_lat ? ST_STOP : ST_IDLE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and one-cycle strobes
    always_comb begin
        nxt      = state;
        take     = 1'b0;
        rx_ld    = 1'b0;
        set_nack = 1'b0;
        set_tmo  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_pending) begin
                    take = 1'b1;
                    nxt  = cmd.addr_frm ? ST_START : ST_BITS;
                end
            end
            ST_START: begin
                if (be_done) begin
                    set_tmo = be_timeout;
                    nxt     = be_timeout ? ST_STOP : ST_BITS;
                end
            end
            ST_BITS: begin
                if (be_done) begin
                    if (be_timeout) begin
                        set_tmo = 1'b1;
                        nxt     = ST_STOP;
                    end else if (bitcnt == LAST_BIT) begin
                        nxt = rd_phase ? ST_RXPUT : ST_ACK;
                    end
                end
            end
            ST_RXPUT: begin
                if (!rx_full) begin
                    rx_ld = 1'b1;
                    nxt   = ST_ACK;
                end
            end
            ST_ACK: begin
                if (be_done) begin
                    if (be_timeout) begin
                        set_tmo = 1'b1;
                        nxt     = ST_STOP;
                    end else if (!rd_phase && be_sda_in) begin
                        set_nack = 1'b1;
                        nxt      = ST_STOP;
                    end else if (is_addr) begin
                        if (remain == '0) nxt = end_st;
                        else if (rw_lat)  nxt = ST_BITS;
                        else              nxt = ST_IDLE;
                    end else if (last_byte) begin
                        nxt = end_st;
                    end else begin
                        nxt = rd_phase ? ST_BITS : ST_IDLE;
                    end
                end
            end
            ST_STOP: begin
                if (be_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // message datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            is_addr  <= 1'b0;
            rw_lat   <= 1'b0;
            stop_lat <= 1'b0;
            remain   <= '0;
        end else begin
            if (take) begin
                shreg   <= cmd.data;
                bitcnt  <= '0;
                is_addr <= cmd.addr_frm;
                if (cmd.addr_frm) begin
                    rw_lat   <= cmd.data[0];
                    stop_lat <= cmd.stop_req;
                    remain   <= cmd.cnt;
                end
            end
            if (state == ST_BITS && be_done && !be_timeout) begin
                shreg  <= {shreg[DATA_W-2:0], be_sda_in};
                bitcnt <= bitcnt + BIT_W'(1);
            end
            if (state == ST_ACK && be_done) begin
                is_addr <= 1'b0;
                bitcnt  <= '0;
                shreg   <= '1;
                if (!is_addr && remain != '0)
                    remain <= remain - ONE_CNT;
                if (nxt != ST_BITS)
                    rw_lat <= 1'b0;
            end
            if (nxt == ST_STOP && state != ST_STOP) begin
                rw_lat <= 1'b0;
                remain <= '0;
            end
        end
    end

    // bus request outputs
    always_comb begin
        be_req     = 1'b0;
        be_op      = OP_BIT;
        be_sda_out = 1'b1;
        unique case (state)
            ST_START: begin
                be_req = 1'b1;
                be_op  = OP_START;
            end
            ST_BITS: begin
                be_req     = 1'b1;
                be_sda_out = rd_phase ? 1'b1 : shreg[DATA_W-1];
            end
            ST_ACK: begin
                be_req     = 1'b1;
                be_sda_out = rd_phase ? last_byte : 1'b1;
            end
            ST_STOP: begin
                be_req = 1'b1;
                be_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // R5: a request is held unchanged until the engine reports done
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_done) |=> (be_req && $stable(be_op) && $stable(be_sda_out)));

    // R6: a NACK flag rise coincides with a STOP request
    a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[FL_NACK]) |-> (be_req && be_op == OP_STOP));

    // R11: a timeout flag rise coincides with a STOP request
    a_r11_tmo_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[FL_TMO]) |-> (be_req && be_op == OP_STOP));

    // R8: while the receive register holds a byte and a read byte is waiting, no request
    a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RXPUT) |-> !be_req);
endmodule

// File: tb/i2cm_xact_ctrl_tb_top.sv
module i2cm_xact_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [31:0] cmd_word;
    logic        cmd_pending;
    logic        rx_rd;
    logic [15:0] rx_word;
    logic        rx_full;
    logic [4:0]  flag_clr;
    logic [4:0]  irq_flags;
    logic        be_req;
    logic [1:0]  be_op;
    logic        be_sda_out;
    logic        be_done;
    logic        be_sda_in;
    logic        be_timeout;

    always #5 clk = ~clk;

    i2cm_xact_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_pending(cmd_pending), .rx_rd(rx_rd), .rx_word(rx_word), .rx_full(rx_full),
        .flag_clr(flag_clr), .irq_flags(irq_flags), .be_req(be_req), .be_op(be_op),
        .be_sda_out(be_sda_out), .be_done(be_done), .be_sda_in(be_sda_in),
        .be_timeout(be_timeout)
    );

    // {addr[6:0], data[7:0], nack_on_address}
    localparam logic [15:0] WVEC [0:5] = '{
        {7'h27, 8'h01, 1'b0},
        {7'h27, 8'hA5, 1'b0},
        {7'h50, 8'h02, 1'b0},
        {7'h7F, 8'hFF, 1'b0},
        {7'h00, 8'h00, 1'b0},
        {7'h31, 8'h5A, 1'b1}
    };

    int n_chk = 0, n_fail = 0;

    // bit engine model state
    bit         eng_busy;
    int         eng_cnt;
    logic [1:0] lat_op;
    logic       lat_sda;
    int bitpos = 0, frm = 0, nlog = 0, start_cnt = 0, stop_cnt = 0;
    int bitop_cnt = 0, op_total = 0, tmo_at = -1, nack_frame = -1;
    logic       rd_mode = 1'b0;
    logic [7:0] cur = '0, sbase = '0, tmpb;
    logic [7:0] wlog [0:63];
    logic       alog [0:63];

    task automatic chkeq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcmd(input logic [7:0] d, input logic txie,
                                          input logic st, input logic stp,
                                          input logic [7:0] cnt);
        return {2'b10, d, 1'b0, 2'b01, txie, 1'b1, st, stp, cnt, 7'b0};
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic wait_free();
        while (cmd_pending) @(negedge clk);
    endtask

    task automatic clr_flags(input logic [4:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] exp_d, input logic exp_ack);
        while (!rx_full) @(negedge clk);
        chkeq(req, 32'(rx_word[15:8]), 32'(exp_d));
        chkeq(req, 32'(rx_word[7]), 32'(exp_ack));
        chkeq(req, 32'(irq_flags[1]), 32'd1);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_stop(input int base);
        while (stop_cnt == base) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // bit engine and slave model
    always @(negedge clk) begin
        if (!rst_n) begin
            be_done    = 1'b0;
            be_timeout = 1'b0;
            be_sda_in  = 1'b1;
            eng_busy   = 1'b0;
        end else if (be_done) begin
            be_done    = 1'b0;
            be_timeout = 1'b0;
        end else if (eng_busy) begin
            if (eng_cnt > 0) begin
                eng_cnt--;
            end else begin
                if (op_total == tmo_at) be_timeout = 1'b1;
                op_total++;
                case (lat_op)
                    2'd0: begin start_cnt++; bitpos = 0; frm = 0; end
                    2'd1: stop_cnt++;
                    default: begin
                        bitop_cnt++;
                        if (bitpos < 8) begin
                            if (frm > 0 && rd_mode) begin
                                tmpb      = sbase + 8'(frm);
                                be_sda_in = tmpb[3'(7 - bitpos)];
                            end else begin
                                be_sda_in = lat_sda;
                            end
                            cur = {cur[6:0], be_sda_in};
                            bitpos++;
                        end else begin
                            if (frm > 0 && rd_mode) be_sda_in = lat_sda;
                            else                    be_sda_in = (nlog == nack_frame);
                            alog[nlog] = be_sda_in;
                            wlog[nlog] = cur;
                            if (frm == 0) rd_mode = cur[0];
                            nlog++;
                            frm++;
                            bitpos = 0;
                        end
                    end
                endcase
                be_done  = 1'b1;
                eng_busy = 1'b0;
            end
        end else if (be_req) begin
            lat_op   = be_op;
            lat_sda  = be_sda_out;
            eng_busy = 1'b1;
            eng_cnt  = 2;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int b_log, b_stop, b_start, b_op, b_bit;
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0; rx_rd = 1'b0; flag_clr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chkeq("R1 flags", 32'(irq_flags), 32'd0);
        chkeq("R1 pending", 32'(cmd_pending), 32'd0);
        chkeq("R1 rx_full", 32'(rx_full), 32'd0);
        chkeq("R1 be_req", 32'(be_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of single-byte write messages
        for (int i = 0; i < 6; i++) begin
            logic [6:0] a;
            logic [7:0] d;
            logic       nk;
            a = WVEC[i][15:9]; d = WVEC[i][8:1]; nk = WVEC[i][0];
            b_log = nlog; b_stop = stop_cnt; b_start = start_cnt;
            nack_frame = nk ? nlog : -1;
            send(mkcmd({a, 1'b0}, 1'b1, 1'b1, 1'b1, 8'd1));
            wait_free();
            if (!nk) send(mkcmd(d, 1'b0, 1'b0, 1'b0, 8'd0));
            wait_stop(b_stop);
            chkeq("R4 one start", 32'(start_cnt - b_start), 32'd1);
            chkeq("R5 address byte", 32'(wlog[b_log]), 32'({a, 1'b0}));
            chkeq("R3 tx flag", 32'(irq_flags[0]), 32'd1);
            chkeq("R9 stop issued", 32'(stop_cnt - b_stop), 32'd1);
            if (nk) begin
                chkeq("R6 only address sent", 32'(nlog - b_log), 32'd1);
                chkeq("R6 nack flag", 32'(irq_flags[2]), 32'd1);
            end else begin
                chkeq("R5 data byte", 32'(wlog[b_log + 1]), 32'(d));
                chkeq("R4 data no start", 32'(nlog - b_log), 32'd2);
                chkeq("R6 no nack", 32'(irq_flags[2]), 32'd0);
            end
            nack_frame = -1;
            clr_flags(5'h1F);
            chkeq("R12 cleared", 32'(irq_flags), 32'd0);
        end

        // R7 read of three bytes, no tx interrupt
        sbase = 8'h40; b_stop = stop_cnt; b_log = nlog;
        send(mkcmd({7'h27, 1'b1}, 1'b0, 1'b1, 1'b1, 8'd3));
        read_byte("R7 byte0", 8'h41, 1'b0);
        read_byte("R7 byte1", 8'h42, 1'b0);
        read_byte("R7 byte2 last", 8'h43, 1'b1);
        wait_stop(b_stop);
        chkeq("R7 frames", 32'(nlog - b_log), 32'd4);
        chkeq("R7 ack low mid", 32'(alog[b_log + 1]), 32'd0);
        chkeq("R7 last released", 32'(alog[b_log + 3]), 32'd1);
        chkeq("R3 no tx flag", 32'(irq_flags[0]), 32'd0);
        clr_flags(5'h1F);

        // R9 combined message with repeated start
        b_log = nlog; b_stop = stop_cnt; b_start = start_cnt;
        send(mkcmd({7'h27, 1'b0}, 1'b1, 1'b1, 1'b0, 8'd2));
        wait_free();
        send(mkcmd(8'h1E, 1'b0, 1'b0, 1'b0, 8'd0));
        wait_free();
        send(mkcmd(8'h85, 1'b0, 1'b0, 1'b0, 8'd0));
        while (nlog < b_log + 3) @(negedge clk);
        repeat (20) @(negedge clk);
        chkeq("R9 no stop yet", 32'(stop_cnt - b_stop), 32'd0);
        chkeq("R9 bus held idle", 32'(be_req), 32'd0);
        chkeq("R5 second data", 32'(wlog[b_log + 2]), 32'h85);
        sbase = 8'h58;
        send(mkcmd({7'h27, 1'b1}, 1'b0, 1'b1, 1'b1, 8'd2));
        read_byte("R9 rd byte0", 8'h59, 1'b0);
        read_byte("R9 rd byte1", 8'h5A, 1'b1);
        wait_stop(b_stop);
        chkeq("R9 two starts", 32'(start_cnt - b_start), 32'd2);
        chkeq("R9 one stop", 32'(stop_cnt - b_stop), 32'd1);
        chkeq("R9 readdress", 32'(wlog[b_log + 3]), 32'h4F);
        clr_flags(5'h1F);

        // R10 zero count
        b_log = nlog; b_stop = stop_cnt;
        send(mkcmd({7'h12, 1'b0}, 1'b0, 1'b1, 1'b1, 8'd0));
        wait_stop(b_stop);
        chkeq("R10 address only", 32'(nlog - b_log), 32'd1);
        chkeq("R10 stop", 32'(stop_cnt - b_stop), 32'd1);

        // R2 invalid word ignored
        b_op = op_total;
        send(mkcmd(8'hAA, 1'b1, 1'b1, 1'b1, 8'd1) & ~32'h0002_0000);
        repeat (20) @(negedge clk);
        chkeq("R2 not pending", 32'(cmd_pending), 32'd0);
        chkeq("R2 no bus op", 32'(op_total - b_op), 32'd0);
        chkeq("R2 no tx flag", 32'(irq_flags[0]), 32'd0);

        // R2 overrun
        b_log = nlog; b_stop = stop_cnt;
        send(mkcmd({7'h44, 1'b0}, 1'b0, 1'b1, 1'b1, 8'd2));
        wait_free();
        send(mkcmd(8'h11, 1'b0, 1'b0, 1'b0, 8'd0));
        send(mkcmd(8'h22, 1'b0, 1'b0, 1'b0, 8'd0));
        chkeq("R2 overrun flag", 32'(irq_flags[4]), 32'd1);
        wait_free();
        send(mkcmd(8'h33, 1'b0, 1'b0, 1'b0, 8'd0));
        wait_stop(b_stop);
        chkeq("R2 kept word", 32'(wlog[b_log + 1]), 32'h11);
        chkeq("R2 dropped word", 32'(wlog[b_log + 2]), 32'h33);
        chkeq("R2 frame count", 32'(nlog - b_log), 32'd3);
        clr_flags(5'h1F);

        // R8 receive stall
        sbase = 8'h90; b_bit = bitop_cnt; b_stop = stop_cnt;
        send(mkcmd({7'h27, 1'b1}, 1'b0, 1'b1, 1'b1, 8'd2));
        while (bitop_cnt < b_bit + 26) @(negedge clk);
        repeat (15) @(negedge clk);
        chkeq("R8 no request", 32'(be_req), 32'd0);
        chkeq("R8 ops held", 32'(bitop_cnt - b_bit), 32'd26);
        chkeq("R8 first byte kept", 32'(rx_word[15:8]), 32'h91);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        repeat (2) @(negedge clk);
        read_byte("R8 second byte", 8'h92, 1'b1);
        wait_stop(b_stop);
        clr_flags(5'h1F);

        // R11 timeout mid-byte
        b_log = nlog; b_stop = stop_cnt;
        tmo_at = op_total + 3;
        send(mkcmd({7'h27, 1'b0}, 1'b0, 1'b1, 1'b1, 8'd1));
        wait_stop(b_stop);
        tmo_at = -1;
        chkeq("R11 timeout flag", 32'(irq_flags[3]), 32'd1);
        chkeq("R11 abandoned", 32'(nlog - b_log), 32'd0);
        chkeq("R11 stop", 32'(stop_cnt - b_stop), 32'd1);
        repeat (10) @(negedge clk);
        chkeq("R11 back idle", 32'(be_req), 32'd0);

        // R12 partial clear
        clr_flags(5'h01);
        chkeq("R12 other flag kept", 32'(irq_flags[3]), 32'd1);
        clr_flags(5'h08);
        chkeq("R12 cleared by w1c", 32'(irq_flags[3]), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule